// File: doc/BRIEF.md
# Byte-Parity Dual-Port RAM

A synchronous RAM with one write port and one read port. Every byte lane is stored with a ninth bit. In normal operation the block fills that bit with the even parity of the byte on write. On read it recomputes the parity and raises a per-lane error flag when the stored bit disagrees. When the user-bit mode input is high, the ninth bit is written from an external input, and no error flags are produced for reads made in that mode.

Writes are masked per lane by byte enables. A parameter adds a registered output stage, which costs one more cycle of read latency. A second parameter moves the read capture to the falling clock edge, so that data is valid before the rising edge that ends the cycle in which the read was issued. The default size is 128 words of four lanes, which gives 4608 stored bits including parity.

Top module: `bp_dpram`

## Requirements
- R1: Lane i occupies data bits [8i+7:8i]. When a lane is written with user_mode low, its stored ninth bit becomes the XOR of its eight data bits (even parity), and rd_ubits[i] returns that stored bit.
- R2: Only lanes with wr_be[i]=1 are written when wr_en=1. A disabled lane keeps both its data and its ninth bit. Nothing is written while wr_en=0.
- R3: When a lane is written with user_mode high, its ninth bit is taken from wr_ubits[i] and the parity generator is not used.
- R4: A read made with user_mode low sets rd_perr[i]=1 exactly when the stored ninth bit of lane i differs from the XOR of the lane's stored data.
- R5: A read made with user_mode high returns rd_perr all zero.
- R6: With PSEUDO_ASYNC=0, the read address is captured on the rising edge. The result appears after that edge when OUT_REG=0, and one rising edge later when OUT_REG=1.
- R7: With PSEUDO_ASYNC=1, rd_en, rd_addr and user_mode are captured on the falling edge, and the result is valid before the next rising edge. OUT_REG is ignored.
- R8: A read of the address being written in the same cycle returns the contents from before that write.
- R9: While rd_en is low, rd_data, rd_ubits and rd_perr hold their previous values.
- R10: While rst_n is low, rd_data, rd_ubits and rd_perr are zero.
- R11: rd_perr always describes the word shown on rd_data in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the read outputs |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write word address |
| wr_data | input | 8*LANES | Write data |
| wr_be | input | LANES | Per-lane write enables |
| user_mode | input | 1 | Ninth bit is a user bit (write source, and error suppression on read) |
| wr_ubits | input | LANES | User bits written in user mode |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | AW | Read word address |
| rd_data | output | 8*LANES | Read data |
| rd_ubits | output | LANES | Stored ninth bits of the read word |
| rd_perr | output | LANES | Per-lane parity mismatch flags |

## Verification
The assertions assume that every address read has been written earlier, so stored bits are never unknown. They also assume that inputs change only between edges and stay stable across both clock edges of a cycle, which the falling-edge capture requires. The bench writes every address in full before it issues any read. It drives all inputs two nanoseconds after the rising edge and samples two nanoseconds before the next one. Parity errors come only from user-mode writes whose bits deliberately disagree with the data, read back later in normal mode.

// File: rtl/bp_dpram.sv
module bp_dpram #(
  parameter int LANES        = 4,
  parameter int DEPTH        = 128,
  parameter bit OUT_REG      = 1'b0,
  parameter bit PSEUDO_ASYNC = 1'b0,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = LANES * 8,
  localparam int SW = LANES * 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [LANES-1:0] wr_be,
  input  logic          user_mode,
  input  logic [LANES-1:0] wr_ubits,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [LANES-1:0] rd_ubits,
  output logic [LANES-1:0] rd_perr
);

  logic [SW-1:0] mem [DEPTH];
  logic [SW-1:0] wr_word, rd_word;
  logic [DW-1:0] nx_data;
  logic [LANES-1:0] nx_ubits, nx_perr;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr_word[9*i +: 8] = wr_data[8*i +: 8];
      wr_word[9*i + 8]  = user_mode ? wr_ubits[i] : ^wr_data[8*i +: 8];
    end
  end

  always_ff @(posedge clk)
    if (wr_en)
      for (int i = 0; i < LANES; i++)
        if (wr_be[i]) mem[wr_addr][9*i +: 9] <= wr_word[9*i +: 9];

  assign rd_word = mem[rd_addr];

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      nx_data[8*i +: 8] = rd_word[9*i +: 8];
      nx_ubits[i]       = rd_word[9*i + 8];
      nx_perr[i]        = !user_mode && (rd_word[9*i + 8] != ^rd_word[9*i +: 8]);
    end
  end

  logic [DW-1:0]    q_data;
  logic [LANES-1:0] q_ubits, q_perr;

  generate
    if (PSEUDO_ASYNC) begin : g_fall
      always_ff @(negedge clk or negedge rst_n)
        if (!rst_n) {q_data, q_ubits, q_perr} <= '0;
        else if (rd_en) {q_data, q_ubits, q_perr} <= {nx_data, nx_ubits, nx_perr};
      assign {rd_data, rd_ubits, rd_perr} = {q_data, q_ubits, q_perr};
    end else begin : g_rise
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) {q_data, q_ubits, q_perr} <= '0;
        else if (rd_en) {q_data, q_ubits, q_perr} <= {nx_data, nx_ubits, nx_perr};
      if (OUT_REG) begin : g_oreg
        logic en_q;
        logic [DW-1:0]    o_data;
        logic [LANES-1:0] o_ubits, o_perr;
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) begin
            en_q <= 1'b0;
            {o_data, o_ubits, o_perr} <= '0;
          end else begin
            en_q <= rd_en;
            if (en_q) {o_data, o_ubits, o_perr} <= {q_data, q_ubits, q_perr};
          end
        assign {rd_data, rd_ubits, rd_perr} = {o_data, o_ubits, o_perr};
      end else begin : g_noreg
        assign {rd_data, rd_ubits, rd_perr} = {q_data, q_ubits, q_perr};
      end
    end
  endgenerate

endmodule

// File: rtl/bp_dpram_chk.sv
module bp_dpram_chk #(
  parameter int LANES        = 4,
  parameter bit OUT_REG      = 1'b0,
  parameter bit PSEUDO_ASYNC = 1'b0
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic             user_mode,
  input logic [LANES*8-1:0] rd_data,
  input logic [LANES-1:0] rd_ubits,
  input logic [LANES-1:0] rd_perr
);
  logic en_d1, um_d1, past_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {en_d1, um_d1, past_ok} <= '0;
    else {en_d1, um_d1, past_ok} <= {rd_en, user_mode, 1'b1};

  always @(posedge clk) begin
    if (!rst_n)
      p_reset_clear_r10: assert (rd_data == '0 && rd_perr == '0 && rd_ubits == '0);
    else
      p_outputs_known_r1: assert (!$isunknown({rd_data, rd_ubits, rd_perr}));
  end

  generate
    if (PSEUDO_ASYNC) begin : g_pa
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && !rd_en |-> $stable(rd_data) && $stable(rd_perr) && $stable(rd_ubits));
      p_user_noerr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && user_mode |-> rd_perr == '0);
    end else if (OUT_REG) begin : g_or
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en && !en_d1 |=> $stable(rd_data) && $stable(rd_perr) && $stable(rd_ubits));
      p_user_noerr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        en_d1 && um_d1 |=> rd_perr == '0);
    end else begin : g_nr
      p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data) && $stable(rd_perr) && $stable(rd_ubits));
      p_user_noerr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && user_mode |=> rd_perr == '0);
    end
  endgenerate
endmodule

bind bp_dpram bp_dpram_chk #(.LANES(LANES), .OUT_REG(OUT_REG), .PSEUDO_ASYNC(PSEUDO_ASYNC)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .user_mode(user_mode),
  .rd_data(rd_data), .rd_ubits(rd_ubits), .rd_perr(rd_perr)
);

// File: tb/bp_dpram_bench.sv
module bp_dpram_bench;
  localparam int LANES = 4;
  localparam int DEPTH = 128;
  localparam int AW = 7;
  localparam int MAXC = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, user_mode = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0, wr_ubits = '0;
  logic [31:0] d0, d1, d2;
  logic [3:0] u0, u1, u2, e0, e1, e2;

  int checks = 0, fails = 0, cyc = 0;

  always #10 clk = ~clk;

  bp_dpram #(.LANES(LANES), .DEPTH(DEPTH), .OUT_REG(0), .PSEUDO_ASYNC(0)) u_bp_dpram (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .user_mode, .wr_ubits,
    .rd_en, .rd_addr, .rd_data(d0), .rd_ubits(u0), .rd_perr(e0));
  bp_dpram #(.LANES(LANES), .DEPTH(DEPTH), .OUT_REG(1), .PSEUDO_ASYNC(0)) u_bp_dpram_oreg (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .user_mode, .wr_ubits,
    .rd_en, .rd_addr, .rd_data(d1), .rd_ubits(u1), .rd_perr(e1));
  bp_dpram #(.LANES(LANES), .DEPTH(DEPTH), .OUT_REG(0), .PSEUDO_ASYNC(1)) u_bp_dpram_fall (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .user_mode, .wr_ubits,
    .rd_en, .rd_addr, .rd_data(d2), .rd_ubits(u2), .rd_perr(e2));

  logic [7:0] md [DEPTH][LANES];
  logic       mp [DEPTH][LANES];
  logic [31:0] hd [MAXC];
  logic [3:0]  hu [MAXC], he [MAXC];
  logic [31:0] cd = '0;
  logic [3:0]  cu = '0, ce = '0;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic cmp(string tag, string who, int lat, logic [31:0] d, logic [3:0] u, logic [3:0] e);
    logic [31:0] xd; logic [3:0] xu, xe;
    int k = cyc - lat;
    xd = (k < 0) ? '0 : hd[k];
    xu = (k < 0) ? '0 : hu[k];
    xe = (k < 0) ? '0 : he[k];
    checks++;
    if (d !== xd || u !== xu || e !== xe) begin
      fails++;
      $display("FAIL %s %s cycle %0d: got data=%h ubits=%b perr=%b expected data=%h ubits=%b perr=%b",
               tag, who, cyc, d, u, e, xd, xu, xe);
    end
  endtask

  task automatic step(string tag, bit we, int wa, logic [31:0] wd, logic [3:0] be,
                      bit um, logic [3:0] ub, bit re, int ra);
    @(posedge clk); #2;
    wr_en = we; wr_addr = AW'(wa); wr_data = wd; wr_be = be;
    user_mode = um; wr_ubits = ub; rd_en = re; rd_addr = AW'(ra);
    if (re) begin
      for (int i = 0; i < LANES; i++) begin
        cd[8*i +: 8] = md[ra][i];
        cu[i] = mp[ra][i];
        ce[i] = !um && (mp[ra][i] != ^md[ra][i]);
      end
    end
    hd[cyc] = cd; hu[cyc] = cu; he[cyc] = ce;
    if (we)
      for (int i = 0; i < LANES; i++)
        if (be[i]) begin
          md[wa][i] = wd[8*i +: 8];
          mp[wa][i] = um ? ub[i] : ^wd[8*i +: 8];
        end
    @(negedge clk); #8;
    cmp(tag, "rise", 1, d0, u0, e0);
    cmp(tag, "oreg", 2, d1, u1, e1);
    cmp(tag, "fall", 0, d2, u2, e2);
    cyc++;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #8;
    checks++;
    if ({d0, u0, e0, d1, u1, e1, d2, u2, e2} !== '0) begin
      fails++;
      $display("FAIL R10 reset: got %h %h %h expected 0", d0, d1, d2);
    end
    @(posedge clk); #2 rst_n = 1'b1;

    // R1: fill every word in normal mode
    for (int a = 0; a < DEPTH; a++)
      step("R1", 1, a, {8'(a), 8'(a * 3 + 1), 8'(~a), 8'(a ^ 8'h5a)}, 4'hf, 0, 4'h0, 0, 0);
    for (int a = 0; a < 6; a++) step("R6", 0, 0, 0, 0, 0, 0, 1, a * 17);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 127);
    step("R7", 0, 0, 0, 0, 0, 0, 1, 0);

    // R2: partial lanes and disabled writes
    step("R2", 1, 9, 32'hdeadbeef, 4'b0101, 0, 0, 0, 0);
    step("R2", 1, 9, 32'h11223344, 4'b1111, 0, 0, 1, 9);
    step("R2", 0, 9, 0, 0, 0, 0, 1, 9);
    step("R2", 0, 10, 32'hffffffff, 4'hf, 0, 0, 1, 10);
    step("R2", 1, 10, 32'h01020304, 4'b0000, 0, 0, 1, 10);
    step("R2", 0, 0, 0, 0, 0, 0, 1, 10);

    // R3/R4/R5: user bits, then parity check
    step("R3", 1, 20, 32'h0f0f0f01, 4'hf, 1, 4'b1010, 0, 0);
    step("R3", 1, 21, 32'h00000000, 4'b0011, 1, 4'b0011, 1, 20);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 20);
    step("R4", 0, 0, 0, 0, 0, 0, 1, 21);
    step("R5", 0, 0, 0, 0, 1, 0, 1, 20);
    step("R5", 0, 0, 0, 0, 1, 0, 1, 21);
    step("R11", 0, 0, 0, 0, 0, 0, 1, 22);

    // R8: same-cycle read and write
    step("R8", 1, 30, 32'hcafef00d, 4'hf, 0, 0, 1, 30);
    step("R8", 0, 0, 0, 0, 0, 0, 1, 30);

    // R9: idle reads while writing
    for (int n = 0; n < 4; n++) step("R9", 1, 40 + n, 32'h55aa55aa + n, 4'hf, 0, 0, 0, 40);
    step("R9", 0, 0, 0, 0, 0, 0, 1, 41);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    step("R9", 0, 0, 0, 0, 0, 0, 0, 0);

    // mixed traffic
    for (int n = 0; n < 400; n++)
      step("R11", 1'($urandom), $urandom % DEPTH, $urandom, 4'($urandom), 1'($urandom % 4 == 0),
           4'($urandom), 1'($urandom), $urandom % DEPTH);

    summary();
    $finish;
  end
endmodule